// File: doc/BRIEF.md
# Circular packet stack address manager

This block generates RAM write addresses for a bus monitor that stores variable-length data packets in a circular stack. The host uses a small eight-entry register file to set a lower and an upper stack boundary, a starting packet address and a fill-warning threshold. Packet words arrive on a valid/ready input. Each accepted word gets the next stack address, and the address wraps from the upper boundary back to the lower boundary.

When the word flagged as last is accepted, the packet closes. The block records the first and final addresses of that packet in read-only entries. It then moves the current packet start to the word after the final one, so the next packet follows on directly. A packet that crosses the wrap point is recorded with a first address greater than its final address. A one-cycle interrupt flags any packet whose word count reaches the programmed threshold.

Top module: `pkt_stack_mgr`

## Requirements
- R1: After reset, all readable entries return zero, `fill_irq_o` is low and `mem_we_o` is low.
- R2: Register entries are decoded from `cfg_addr_i`: index 0 is the stack lower bound, 1 is the current packet start, 2 is the stack upper bound, 3 is the first address of the last closed packet, 4 is its final address and 5 is the fill threshold. Entries 0, 1, 2 and 5 read back what the host wrote. Host writes to entries 3 and 4 are ignored. Entries 6 and 7 read zero.
- R3: The first word after entry 1 is written goes to that address. Each later accepted word goes to the previous address plus one.
- R4: A word accepted at the stack upper bound is followed by a word at the stack lower bound.
- R5: When a word with `wr_last_i` high is accepted, entry 3 takes the packet's first address and entry 4 takes that word's address, both from the next cycle.
- R6: On the same close, entry 1 becomes the address after the final word, wrapped to the lower bound if the final word sat at the upper bound.
- R7: A packet crossing the wrap point is recorded with entry 3 greater than entry 4, and both values lie within the stack bounds.
- R8: `fill_irq_o` is high for the one cycle after the accepted word that brings the current packet's word count to a non-zero threshold. A threshold of 0 gives no pulse. The count restarts with each packet.
- R9: While the host writes entry 0, 1 or 2, `wr_ready_o` is low and no word is accepted. The write pointer is left unchanged by that write, except for a write to entry 1.
- R10: `mem_we_o` is high exactly when `wr_valid_i` and `wr_ready_o` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register index |
| cfg_wdata_i | input | AW | Register write data |
| cfg_rdata_o | output | AW | Register read data for cfg_addr_i |
| wr_valid_i | input | 1 | Packet word offered |
| wr_last_i | input | 1 | Offered word closes the packet |
| wr_ready_o | output | 1 | Word can be accepted |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | AW | RAM write address |
| fill_irq_o | output | 1 | Fill-warning pulse |

## Verification
The bench aims at the following cases, and the failure each would expose:
- A packet that straddles the upper bound. Dropping the wrap would send words past the stack, and an off-by-one compare would skip or duplicate the boundary word.
- A packet ending exactly on the upper bound, so that the next start must wrap to the lower bound. A design that forgets this would point the next packet outside the stack.
- The fill threshold across packet boundaries and at zero. A counter that is not reset per packet would fire at the wrong word, and a zero threshold must never fire.
- Host writes to boundary entries while a word is offered. The word must stall instead of landing at a half-updated address.
- Host writes to the recorded entries. These must be ignored.

// File: rtl/pkt_stack_pkg.sv
package pkt_stack_pkg;
  typedef enum logic [2:0] {
    IDX_STK_LO    = 3'd0,
    IDX_CUR       = 3'd1,
    IDX_STK_HI    = 3'd2,
    IDX_PKT_FIRST = 3'd3,
    IDX_PKT_LAST  = 3'd4,
    IDX_FILL_THR  = 3'd5
  } cfg_idx_e;

  localparam logic [2:0] CFG_HOLD_LIMIT = 3'd3;  // indices below this stall words
endpackage

// File: rtl/pkt_stack_regs.sv
module pkt_stack_regs #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] rdata_o,
  input  logic          close_i,
  input  logic [AW-1:0] next_start_i,
  input  logic [AW-1:0] last_addr_i,
  output logic [AW-1:0] stk_lo_o,
  output logic [AW-1:0] stk_hi_o,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] thr_o,
  output logic [AW-1:0] pkt_first_o,
  output logic [AW-1:0] pkt_last_o,
  output logic          cur_load_o
);
  import pkt_stack_pkg::*;

  logic [AW-1:0] stk_lo_q, stk_hi_q, cur_q, thr_q, first_q, last_q;

  assign cur_load_o = we_i && (addr_i == IDX_CUR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stk_lo_q <= '0;
      stk_hi_q <= '0;
      cur_q    <= '0;
      thr_q    <= '0;
      first_q  <= '0;
      last_q   <= '0;
    end else begin
      if (we_i && addr_i == IDX_STK_LO)   stk_lo_q <= wdata_i;
      if (we_i && addr_i == IDX_STK_HI)   stk_hi_q <= wdata_i;
      if (we_i && addr_i == IDX_FILL_THR) thr_q    <= wdata_i;
      if (cur_load_o) begin
        cur_q <= wdata_i;
      end else if (close_i) begin
        cur_q <= next_start_i;
      end
      if (close_i) begin
        first_q <= cur_q;
        last_q  <= last_addr_i;
      end
    end
  end

  always_comb begin
    case (addr_i)
      IDX_STK_LO:    rdata_o = stk_lo_q;
      IDX_CUR:       rdata_o = cur_q;
      IDX_STK_HI:    rdata_o = stk_hi_q;
      IDX_PKT_FIRST: rdata_o = first_q;
      IDX_PKT_LAST:  rdata_o = last_q;
      IDX_FILL_THR:  rdata_o = thr_q;
      default:       rdata_o = '0;
    endcase
  end

  assign stk_lo_o    = stk_lo_q;
  assign stk_hi_o    = stk_hi_q;
  assign cur_o       = cur_q;
  assign thr_o       = thr_q;
  assign pkt_first_o = first_q;
  assign pkt_last_o  = last_q;
endmodule

// File: rtl/pkt_stack_addr_gen.sv
module pkt_stack_addr_gen #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          last_i,
  input  logic          hold_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic [AW-1:0] stk_lo_i,
  input  logic [AW-1:0] stk_hi_i,
  input  logic [AW-1:0] thr_i,
  output logic          ready_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] next_o,
  output logic          close_o,
  output logic          irq_o
);
  localparam int CW = AW + 1;

  logic [AW-1:0] wptr_q;
  logic [CW-1:0] cnt_q, cnt_inc;
  logic          irq_q, accept, hit;

  assign ready_o = !hold_i;
  assign accept  = valid_i && ready_o;
  assign we_o    = accept;
  assign addr_o  = wptr_q;
  assign next_o  = (wptr_q == stk_hi_i) ? stk_lo_i : wptr_q + 1'b1;
  assign close_o = accept && last_i;
  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = accept && (thr_i != '0) && (cnt_inc == {1'b0, thr_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= hit;
      if (load_i) begin
        wptr_q <= load_val_i;
        cnt_q  <= '0;
      end else if (accept) begin
        wptr_q <= next_o;
        cnt_q  <= last_i ? '0 : cnt_inc;
      end
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pkt_stack_mgr.sv
module pkt_stack_mgr #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic [AW-1:0] cfg_rdata_o,
  input  logic          wr_valid_i,
  input  logic          wr_last_i,
  output logic          wr_ready_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          fill_irq_o
);
  import pkt_stack_pkg::*;

  logic [AW-1:0] stk_lo, stk_hi, cur, thr, pkt_first, pkt_last, nxt;
  logic          close, cur_load, hold;

  assign hold = cfg_we_i && (cfg_addr_i < CFG_HOLD_LIMIT);

  pkt_stack_regs #(.AW(AW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i),
    .addr_i       (cfg_addr_i),
    .wdata_i      (cfg_wdata_i),
    .rdata_o      (cfg_rdata_o),
    .close_i      (close),
    .next_start_i (nxt),
    .last_addr_i  (mem_addr_o),
    .stk_lo_o     (stk_lo),
    .stk_hi_o     (stk_hi),
    .cur_o        (cur),
    .thr_o        (thr),
    .pkt_first_o  (pkt_first),
    .pkt_last_o   (pkt_last),
    .cur_load_o   (cur_load)
  );

  pkt_stack_addr_gen #(.AW(AW)) u_agen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (wr_valid_i),
    .last_i     (wr_last_i),
    .hold_i     (hold),
    .load_i     (cur_load),
    .load_val_i (cfg_wdata_i),
    .stk_lo_i   (stk_lo),
    .stk_hi_i   (stk_hi),
    .thr_i      (thr),
    .ready_o    (wr_ready_o),
    .we_o       (mem_we_o),
    .addr_o     (mem_addr_o),
    .next_o     (nxt),
    .close_o    (close),
    .irq_o      (fill_irq_o)
  );
endmodule

// File: rtl/pkt_stack_mgr_chk.sv
module pkt_stack_mgr_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [2:0]    cfg_addr_i,
  input logic          wr_valid_i,
  input logic          wr_last_i,
  input logic          wr_ready_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          fill_irq_o,
  input logic [AW-1:0] stk_lo,
  input logic [AW-1:0] stk_hi,
  input logic [AW-1:0] pkt_last
);
  assert_we_handshake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o == (wr_valid_i && wr_ready_o));

  assert_cfg_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i < 3'd3) |-> !mem_we_o);

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o != stk_hi && !cfg_we_i) |=>
      (!mem_we_o || mem_addr_o == $past(mem_addr_o) + 1'b1));

  assert_addr_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o == stk_hi && !cfg_we_i) |=>
      (!mem_we_o || mem_addr_o == $past(stk_lo)));

  assert_close_records_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && wr_last_i) |=> pkt_last == $past(mem_addr_o));

  assert_irq_follows_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_irq_o |-> $past(mem_we_o));
endmodule

bind pkt_stack_mgr pkt_stack_mgr_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .wr_valid_i (wr_valid_i),
  .wr_last_i  (wr_last_i),
  .wr_ready_o (wr_ready_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .fill_irq_o (fill_irq_o),
  .stk_lo     (stk_lo),
  .stk_hi     (stk_hi),
  .pkt_last   (pkt_last)
);

// File: tb/pkt_stack_mgr_tb.sv
module pkt_stack_mgr_tb;
  localparam int AW = 8;
  localparam int CLK_P = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [2:0]    cfg_addr_i = '0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic [AW-1:0] cfg_rdata_o;
  logic          wr_valid_i = 1'b0;
  logic          wr_last_i = 1'b0;
  logic          wr_ready_o;
  logic          mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic          fill_irq_o;

  int total = 0;
  int bad = 0;
  logic [AW-1:0] exp_addr;
  int thr_m = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  pkt_stack_mgr #(.AW(AW)) u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
  endtask

  task automatic cfg_rd(input logic [2:0] a, output logic [AW-1:0] d);
    @(negedge clk_i);
    cfg_addr_i = a; #1;
    d = cfg_rdata_o;
  endtask

  // one packet; checks address, wrap and fill pulse of every word
  task automatic send_pkt(input int n, input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      wr_valid_i = 1'b1; wr_last_i = (i == n - 1); #1;
      check("R3/R4 addr", mem_addr_o, exp_addr);
      check("R10 we", mem_we_o, 1);
      @(posedge clk_i); #1;
      check("R8 irq", fill_irq_o, (thr_m != 0 && i + 1 == thr_m));
      exp_addr = (exp_addr == hi) ? lo : exp_addr + 1'b1;
    end
    @(negedge clk_i);
    wr_valid_i = 1'b0; wr_last_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [AW-1:0] d;
    for (int k = 0; k < 8; k++) begin
      cfg_rd(k[2:0], d);
      check("R1 reset entry", d, 0);
    end
    check("R1 irq", fill_irq_o, 0);
    check("R1 we", mem_we_o, 0);
  endtask

  task automatic t_regs;
    logic [AW-1:0] d;
    cfg_wr(3'd0, 8'h10); cfg_wr(3'd2, 8'h17); cfg_wr(3'd5, 8'd3); cfg_wr(3'd1, 8'h10);
    thr_m = 3; exp_addr = 8'h10;
    cfg_rd(3'd0, d); check("R2 lo", d, 8'h10);
    cfg_rd(3'd2, d); check("R2 hi", d, 8'h17);
    cfg_rd(3'd5, d); check("R2 thr", d, 3);
    cfg_rd(3'd1, d); check("R2 cur", d, 8'h10);
    cfg_wr(3'd3, 8'hAA); cfg_rd(3'd3, d); check("R2 ro entry3", d, 0);
    cfg_wr(3'd4, 8'hBB); cfg_rd(3'd4, d); check("R2 ro entry4", d, 0);
    cfg_wr(3'd6, 8'hCC); cfg_rd(3'd6, d); check("R2 entry6 zero", d, 0);
    cfg_rd(3'd7, d); check("R2 entry7 zero", d, 0);
    @(negedge clk_i); #1; check("R10 idle we", mem_we_o, 0);
  endtask

  task automatic t_plain_pkt;
    logic [AW-1:0] d;
    send_pkt(5, 8'h10, 8'h17);
    cfg_rd(3'd3, d); check("R5 first", d, 8'h10);
    cfg_rd(3'd4, d); check("R5 last", d, 8'h14);
    cfg_rd(3'd1, d); check("R6 next start", d, 8'h15);
  endtask

  task automatic t_wrap_pkt;
    logic [AW-1:0] f, l;
    send_pkt(5, 8'h10, 8'h17);
    cfg_rd(3'd3, f); cfg_rd(3'd4, l);
    check("R7 first", f, 8'h15);
    check("R7 last", l, 8'h11);
    check("R7 first>last", f > l, 1);
    check("R7 in bounds", (l >= 8'h10) && (f <= 8'h17), 1);
    cfg_rd(3'd1, f); check("R6 after wrap", f, 8'h12);
  endtask

  task automatic t_end_at_hi;
    logic [AW-1:0] d;
    cfg_wr(3'd1, 8'h16); exp_addr = 8'h16;
    send_pkt(2, 8'h10, 8'h17);
    cfg_rd(3'd4, d); check("R5 last at hi", d, 8'h17);
    cfg_rd(3'd1, d); check("R6 wrap start", d, 8'h10);
  endtask

  task automatic t_thr_zero;
    cfg_wr(3'd5, 8'd0); thr_m = 0;
    send_pkt(4, 8'h10, 8'h17);
    cfg_wr(3'd5, 8'd1); thr_m = 1;
    send_pkt(2, 8'h10, 8'h17);
    send_pkt(1, 8'h10, 8'h17);
  endtask

  task automatic t_cfg_stall;
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 3'd0; cfg_wdata_i = 8'h10;
    wr_valid_i = 1'b1; wr_last_i = 1'b0; #1;
    check("R9 ready low", wr_ready_o, 0);
    check("R9 no we", mem_we_o, 0);
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0; wr_valid_i = 1'b0;
    send_pkt(2, 8'h10, 8'h17);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 3'd5; cfg_wdata_i = 8'd0; wr_valid_i = 1'b1; #1;
    check("R9 thr write no stall", wr_ready_o, 1);
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0; wr_valid_i = 1'b0;
    exp_addr = (exp_addr == 8'h17) ? 8'h10 : exp_addr + 1'b1;
    thr_m = 0;
    send_pkt(1, 8'h10, 8'h17);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 3);
    t_reset();
    @(negedge clk_i); rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_plain_pkt();
    t_wrap_pkt();
    t_end_at_hi();
    t_thr_zero();
    t_cfg_stall();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule